// File: doc/BRIEF.md
# Interrupt Pending and Working-Bank Control Word

This block is a single 16-bit control and status word for a small processor. It holds two kinds of state. One is a plain read/write selector that names the current working register bank, 0 to 15. The other is a set of eight sticky pending flags, one per interrupt source, which software clears by writing 1.

The eight sources each deliver a single-cycle event pulse: converter done, serial peripheral, three timers and three external pins. Each pulse sets its flag, and the flag stays set until software clears it. The block outputs the bank number, the pending vector and one request line that is high while any flag is set.

The two kinds of state share one word, so software can read the word and write the same value back. That one access clears every flag that was pending at the read and leaves the bank unchanged. An interrupt handler can use this to acknowledge all pending sources at once. Prioritisation, vectoring, masking and the bank register file itself live elsewhere.

Top module: `intstat_bank_reg`

## Requirements
- R1: While the reset is asserted and afterwards until the first write or event, the bank is 0, every pending flag is 0, the request line is 0 and the read word is 0.
- R2: Any write loads write-data bits 3:0 into the bank, with no clear semantics. The new bank is visible on the bank output and on read bits 3:0 one cycle after the write.
- R3: An event pulse on source i sets pending flag i on that clock edge. Flag i appears on pending output bit i and on read bit 4+i. The sources in order are: 0 converter done (read bit 4), 1 serial peripheral (bit 5), 2 to 4 timers 0 to 2 (bits 6 to 8), and 5 to 7 external pins 0 to 2 (bits 9 to 11).
- R4: A set flag stays set on later cycles until it is cleared.
- R5: A write with 1 in read bit 4+i clears flag i. A write with 0 in that bit leaves flag i unchanged.
- R6: If an event for a source arrives in the same cycle as a write-1 clear of its flag, the flag ends up set.
- R7: Writing back the word that was just read clears every flag that was pending at the read and leaves the bank unchanged.
- R8: Bits 15:12 always read 0, and writes to them have no effect on any output.
- R9: The request line equals the OR of the eight pending flags and changes on the same edge as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the word |
| wr_data | input | 16 | Write data |
| evt_i | input | 8 | Single-cycle event pulses, one per source, in R3 order |
| rd_data | output | 16 | Read word: bank in 3:0, flags in 11:4, 0 in 15:12 |
| bank_o | output | 4 | Current working bank |
| pend_o | output | 8 | Pending flags, in R3 order |
| irq_any_o | output | 1 | High while any flag is pending |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. A write or an event applied before edge n shows on the bank, the flags, the read word and the request line just after edge n. The bench drives inputs one nanosecond after a rising edge. It compares all outputs with a bench-side model one nanosecond after the next rising edge, before it drives new inputs. The model takes set-over-clear priority and the field positions from the requirements alone. Exhaustive sweeps cover all 16 bank values, all 256 event patterns and all 256 patterns that collide with a clear-all write. A pseudo-random mixed phase follows the sweeps.

// File: rtl/isb_pkg.sv
package isb_pkg;
  localparam int ISB_BANK_W = 4;
  localparam int ISB_NUM_SRC = 8;
  localparam int ISB_WORD_W = 16;

  typedef enum int unsigned {
    SRC_ADC  = 0,
    SRC_SPI  = 1,
    SRC_TMR0 = 2,
    SRC_TMR1 = 3,
    SRC_TMR2 = 4,
    SRC_EXT0 = 5,
    SRC_EXT1 = 6,
    SRC_EXT2 = 7
  } isb_src_e;
endpackage

// File: rtl/isb_rst_sync.sv
module isb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/isb_bank_field.sv
module isb_bank_field #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  output logic [BANK_W-1:0] bank_q
);
  logic              bank_en;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_en = wr_en;
    bank_d  = wr_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

  assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bank_q == $past(wr_bank));
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q));
endmodule

// File: rtl/isb_flag_bank.sv
module isb_flag_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_q,
  output logic               any_q
);
  logic [NUM_SRC-1:0] flag_d;
  logic               any_d;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    always_comb begin
      flag_d[g] = evt_i[g] | (flag_q[g] & ~clr_i[g]);
    end

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> flag_q[g]);
    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !evt_i[g]) |=> !flag_q[g]);
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !evt_i[g]) |=> flag_q[g] == $past(flag_q[g]));
  end

  always_comb begin
    any_d = |flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      any_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      any_q  <= any_d;
    end
  end

  assert_any_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_q == (flag_q != '0));
endmodule

// File: rtl/isb_readback.sv
module isb_readback #(
  parameter int BANK_W  = 4,
  parameter int NUM_SRC = 8,
  parameter int WORD_W  = 16
) (
  input  logic [BANK_W-1:0]  bank_q,
  input  logic [NUM_SRC-1:0] flag_q,
  output logic [WORD_W-1:0]  rd_word
);
  localparam int USED_W = BANK_W + NUM_SRC;

  always_comb begin
    rd_word = '0;
    rd_word[BANK_W-1:0]      = bank_q;
    rd_word[USED_W-1:BANK_W] = flag_q;
  end
endmodule

// File: rtl/intstat_bank_reg.sv
module intstat_bank_reg
  import isb_pkg::*;
#(
  parameter int BANK_W  = ISB_BANK_W,
  parameter int NUM_SRC = ISB_NUM_SRC,
  parameter int WORD_W  = ISB_WORD_W
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [WORD_W-1:0]  rd_data,
  output logic [BANK_W-1:0]  bank_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_any_o
);
  localparam int FLAG_LSB = BANK_W;
  localparam int FLAG_MSB = BANK_W + NUM_SRC - 1;

  logic               rst_n;
  logic [NUM_SRC-1:0] clr_vec;
  logic [BANK_W-1:0]  bank_q;
  logic [NUM_SRC-1:0] flag_q;
  logic               any_q;
  logic               unused_rsvd;

  assign unused_rsvd = ^wr_data[WORD_W-1:FLAG_MSB+1];

  isb_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  always_comb begin
    clr_vec = wr_en ? wr_data[FLAG_MSB:FLAG_LSB] : '0;
  end

  isb_bank_field #(.BANK_W(BANK_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_bank (wr_data[BANK_W-1:0]),
    .bank_q  (bank_q)
  );

  isb_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .clr_i  (clr_vec),
    .flag_q (flag_q),
    .any_q  (any_q)
  );

  isb_readback #(.BANK_W(BANK_W), .NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_rd (
    .bank_q  (bank_q),
    .flag_q  (flag_q),
    .rd_word (rd_data)
  );

  assign bank_o    = bank_q;
  assign pend_o    = flag_q;
  assign irq_any_o = any_q;

  assert_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == rd_data && evt_i == '0) |=> (pend_o == '0 && $stable(bank_o)));
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (evt_i & wr_data[FLAG_MSB:FLAG_LSB]) != '0)
      |=> (pend_o & $past(evt_i & wr_data[FLAG_MSB:FLAG_LSB])) == $past(evt_i & wr_data[FLAG_MSB:FLAG_LSB]));
endmodule

// File: tb/intstat_bank_reg_bench.sv
module intstat_bank_reg_bench;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  evt_i = '0;
  logic [15:0] rd_data;
  logic [3:0]  bank_o;
  logic [7:0]  pend_o;
  logic        irq_any_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] m_bank = '0;
  logic [7:0] m_flag = '0;

  always #2 clk = ~clk;

  intstat_bank_reg u_intstat_bank_reg (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .wr_data(wr_data),
    .evt_i(evt_i), .rd_data(rd_data), .bank_o(bank_o), .pend_o(pend_o),
    .irq_any_o(irq_any_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, {16'h0, rd_data}, {16'h0, 4'h0, m_flag, m_bank});
    check(req, {28'h0, bank_o}, {28'h0, m_bank});
    check(req, {24'h0, pend_o}, {24'h0, m_flag});
    check(req, {31'h0, irq_any_o}, {31'h0, (m_flag != 8'h0)});
  endtask

  // Drive at posedge+1, let one edge capture, update model, check at posedge+1.
  task automatic step(input logic [7:0] ev, input logic we, input logic [15:0] wd, input string req);
    evt_i = ev; wr_en = we; wr_data = wd;
    @(posedge clk); #1;
    m_flag = ev | (m_flag & ~(we ? wd[11:4] : 8'h0));
    if (we) m_bank = wd[3:0];
    evt_i = '0; wr_en = 1'b0; wr_data = '0;
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] snap;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 during reset");
    arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_all("R1 after reset");

    // R2: every bank value, flags untouched (no 1 in flag bits)
    for (int b = 0; b < 16; b++) step(8'h00, 1'b1, 16'(b), "R2 bank load");
    step(8'h00, 1'b0, 16'h0, "R2 bank hold");

    // R3/R9: all event patterns from a cleared state
    for (int p = 0; p < 256; p++) begin
      step(8'h00, 1'b1, {4'h0, 8'hFF, m_bank}, "R5 clear all");
      step(8'(p), 1'b0, 16'h0, "R3 R9 event pattern");
    end

    // R3: single sources land on their own read bit
    for (int i = 0; i < 8; i++) begin
      step(8'h00, 1'b1, {4'h0, 8'hFF, 4'h3}, "R5 clear all");
      step(8'(1 << i), 1'b0, 16'h0, "R3 single source");
      check("R3 read bit position", {16'h0, rd_data}, 32'(16'h0003 | (16'h1 << (4 + i))));
    end

    // R4: stickiness with no activity
    step(8'hA5, 1'b0, 16'h0, "R3 set");
    for (int k = 0; k < 20; k++) step(8'h00, 1'b0, 16'h0, "R4 sticky");

    // R5: write 0 no effect, write 1 per bit
    step(8'hFF, 1'b0, 16'h0, "R3 set all");
    step(8'h00, 1'b1, 16'h0007, "R5 write zero keeps flags");
    check("R5 flags kept", {24'h0, pend_o}, 32'hFF);
    for (int i = 0; i < 8; i++) step(8'h00, 1'b1, 16'(16'h1 << (4 + i)) | 16'h7, "R5 clear one");
    check("R5 all cleared", {24'h0, pend_o}, 32'h0);

    // R6: collision of events with clear-all
    for (int p = 0; p < 256; p++) begin
      step(8'hFF, 1'b0, 16'h0, "R3 set all");
      step(8'(p), 1'b1, {4'h0, 8'hFF, 4'h6}, "R6 set wins");
    end

    // R7: read then write back
    step(8'h00, 1'b1, {4'h0, 8'hFF, 4'h9}, "R7 prep");
    step(8'h3C, 1'b0, 16'h0, "R7 prep events");
    snap = rd_data;
    step(8'h00, 1'b1, snap, "R7 write back");
    check("R7 bank kept", {28'h0, bank_o}, 32'h9);
    check("R7 flags cleared", {24'h0, pend_o}, 32'h0);

    // R8: reserved bits
    step(8'h00, 1'b1, 16'hF00C, "R8 reserved write");
    check("R8 reserved read zero", {28'h0, rd_data[15:12]}, 32'h0);
    check("R8 bank", {28'h0, bank_o}, 32'hC);

    // mixed pseudo-random phase
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(a[7:0] & a[15:8] & lfsr[7:0], lfsr[8] & lfsr[9], {lfsr[15:12], a[11:0]}, "R2 R3 R5 R6 R8 R9 mixed");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule